// File: doc/BRIEF.md
# Divider Configuration Load Controller

This block keeps the control word of a frequency synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test-mode select. The word can reach the block in two ways. The first is a parallel path from dedicated pins, with an active-low load strobe. The second is a three-wire serial path made of a shift clock, a data line and a load strobe. The block presents the divide values that apply at each moment to the divider logic. It also drives a 3-bit test-output select code and the serial output of its shift register. It flags a feedback value that lies outside the range in which the loop can lock, and it applies that value all the same.

All strobes are sampled by the block clock `clk`. Serial edges are found by comparing each strobe with its value one clock earlier. Each phase of the serial clock must therefore last at least one `clk` period. The parallel path takes priority over the serial path: while the parallel strobe is low, the serial path can neither change the shift register nor load a word.

Top module: `divcfg_loader`

## Requirements
- R1: After an asynchronous active-low reset, `m_div` is 200, `n_div` is 0, `test_sel` is 000, `sout` is 0 and `m_range_err` is 0.
- R2: While `pload_n` is low, `m_div` and `n_div` equal `m_pin` and `n_pin` without a clock delay.
- R3: After `pload_n` rises, `m_div` and `n_div` hold the pin values captured on the last clock while `pload_n` was low. Later changes on the pins have no effect.
- R4: With `pload_n` high, each rising edge of `sclk` shifts `sdata` into bit 0 of a 14-bit shift register, and `sout` is its bit 13. After a full 14-bit frame the register holds T2..T0 in bits 13..11, N1..N0 in bits 10..9 and M8..M0 in bits 8..0. The first bit sent therefore lands in T2 and the last bit in M0.
- R5: While `sload` is high with `pload_n` high, `m_div` and `n_div` follow register bits 8..0 and 10..9, starting one clock after `sload` rises. They keep following those bits through any further shifts.
- R6: When `sload` falls with `pload_n` high, the M, N and T fields of the shift register are latched, and `m_div` and `n_div` hold them from that point on.
- R7: `test_sel` carries the latched T field, coded 000 shift-register out, 001 high, 010 reference/16, 011 feedback/2, 100 output, 101 low, 110 serial-clock/M/2, 111 output/4. It reads 000 while `pload_n` is low, and it keeps reading 000 from a parallel load until the next serial latch.
- R8: `m_range_err` is high exactly when `m_div` is below 125 or above 350. The out-of-range value still appears on `m_div`.
- R9: While `pload_n` is low, `sclk` edges leave the shift register unchanged and `sload` edges latch nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| pload_n | input | 1 | Parallel load strobe, active low, transparent while low |
| m_pin | input | 9 | Parallel feedback divide value |
| n_pin | input | 2 | Parallel output divide select |
| sclk | input | 1 | Serial shift clock |
| sdata | input | 1 | Serial data, first bit is T2 |
| sload | input | 1 | Serial load strobe |
| m_div | output | 9 | Feedback divide value in force |
| n_div | output | 2 | Output divide select in force |
| test_sel | output | 3 | Test-output select code |
| sout | output | 1 | Shift register serial output (bit 13) |
| m_range_err | output | 1 | Feedback value outside 125..350 |

## Verification
The hardest state to reach is one in which the shift register and the latched word disagree while the parallel path owns the outputs. To get there, the bench first latches a serial word. It then lowers `pload_n` and sends a complete second frame with an `sload` pulse, all while the parallel strobe is low. When `pload_n` is released and `sload` is raised, `m_div` shows that the old frame survived. A further case keeps `sload` high, shifts in one extra bit, and checks that the outputs track the shifted contents before the latch.

// File: rtl/divcfg_loader.sv
module divcfg_loader #(
  parameter int MW    = 9,
  parameter int NW    = 2,
  parameter int TW    = 3,
  parameter int M_MIN = 125,
  parameter int M_MAX = 350,
  parameter int M_RST = 200,
  parameter int N_RST = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pload_n,
  input  logic [MW-1:0] m_pin,
  input  logic [NW-1:0] n_pin,
  input  logic          sclk,
  input  logic          sdata,
  input  logic          sload,
  output logic [MW-1:0] m_div,
  output logic [NW-1:0] n_div,
  output logic [TW-1:0] test_sel,
  output logic          sout,
  output logic          m_range_err
);
  localparam int FW = MW + NW + TW;
  localparam logic [MW-1:0] M_LO  = M_MIN[MW-1:0];
  localparam logic [MW-1:0] M_HI  = M_MAX[MW-1:0];
  localparam logic [MW-1:0] M_DEF = M_RST[MW-1:0];
  localparam logic [NW-1:0] N_DEF = N_RST[NW-1:0];

  logic [FW-1:0] shreg;
  logic [MW-1:0] m_hold;
  logic [NW-1:0] n_hold;
  logic [TW-1:0] t_reg;
  logic          sclk_q, sload_q, par_mode;

  wire shift_en  = pload_n & sclk & ~sclk_q;
  wire latch_en  = pload_n & sload_q & ~sload;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q   <= 1'b0;
      sload_q  <= 1'b0;
      shreg    <= '0;
      m_hold   <= M_DEF;
      n_hold   <= N_DEF;
      t_reg    <= '0;
      par_mode <= 1'b0;
    end else begin
      sclk_q  <= sclk;
      sload_q <= sload;
      if (shift_en)
        shreg <= {shreg[FW-2:0], sdata};
      if (!pload_n) begin
        m_hold   <= m_pin;
        n_hold   <= n_pin;
        par_mode <= 1'b1;
      end else if (latch_en) begin
        m_hold   <= shreg[MW-1:0];
        n_hold   <= shreg[MW+NW-1:MW];
        t_reg    <= shreg[FW-1:MW+NW];
        par_mode <= 1'b0;
      end
    end
  end

  assign m_div = !pload_n ? m_pin : (sload_q ? shreg[MW-1:0]       : m_hold);
  assign n_div = !pload_n ? n_pin : (sload_q ? shreg[MW+NW-1:MW]   : n_hold);
  assign test_sel    = (!pload_n || par_mode) ? '0 : t_reg;
  assign sout        = shreg[FW-1];
  assign m_range_err = (m_div < M_LO) || (m_div > M_HI);

  AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pload_n && sclk && !sclk_q) |-> shreg == {$past(shreg[FW-2:0]), $past(sdata)}); // R4

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_n && $past(pload_n) && !sload_q && !$past(sload_q))
      |-> ($stable(m_div) && $stable(n_div))); // R3

  AST_LATCH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_n && $past(pload_n) && $fell(sload_q))
      |-> (m_div == $past(shreg[MW-1:0]) && n_div == $past(shreg[MW+NW-1:MW]))); // R6

  AST_LATCH_TEST: assert property (@(posedge clk) disable iff (!rst_n)
    (pload_n && $past(pload_n) && $fell(sload_q))
      |-> test_sel == $past(shreg[FW-1:FW-TW])); // R7

  AST_PAR_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(pload_n) |-> $stable(shreg)); // R9
endmodule

// File: tb/tb_divcfg_loader.sv
module tb_divcfg_loader;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pload_n = 1'b1;
  logic [8:0] m_pin = '0;
  logic [1:0] n_pin = '0;
  logic       sclk = 1'b0, sdata = 1'b0, sload = 1'b0;
  logic [8:0] m_div;
  logic [1:0] n_div;
  logic [2:0] test_sel;
  logic       sout, m_range_err;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  divcfg_loader dut (.clk(clk), .rst_n(rst_n), .pload_n(pload_n), .m_pin(m_pin),
    .n_pin(n_pin), .sclk(sclk), .sdata(sdata), .sload(sload), .m_div(m_div),
    .n_div(n_div), .test_sel(test_sel), .sout(sout), .m_range_err(m_range_err));

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  function automatic int bad(input int m);
    return (m < 125 || m > 350) ? 1 : 0;
  endfunction

  task automatic par_load(input int m, input int n);
    pload_n = 1'b0; m_pin = m[8:0]; n_pin = n[1:0];
    step();
    check(m_div, m, "R2 m pass");
    check(n_div, n, "R2 n pass");
    check(test_sel, 0, "R7 par low");
    check(m_range_err, bad(m), "R8 par");
    pload_n = 1'b1;
    step();
    m_pin = ~m[8:0]; n_pin = ~n[1:0];
    step();
    check(m_div, m, "R3 m hold");
    check(n_div, n, "R3 n hold");
  endtask

  task automatic shift_frame(input logic [13:0] f);
    for (int i = 13; i >= 0; i--) begin
      sdata = f[i]; sclk = 1'b1; step();
      sclk = 1'b0; step();
    end
  endtask

  task automatic ser_load(input int m, input int n, input int t);
    logic [13:0] f;
    f = {t[2:0], n[1:0], m[8:0]};
    shift_frame(f);
    check(sout, t[2], "R4 sout");
    sload = 1'b1; step();
    check(m_div, m, "R5 m transp");
    check(n_div, n, "R5 n transp");
    sload = 1'b0; step();
    check(m_div, m, "R6 m latch");
    check(n_div, n, "R6 n latch");
    check(test_sel, t, "R7 t latch");
    check(m_range_err, bad(m), "R8 ser");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int mlist[8];
    logic [13:0] f;
    step(); step();
    check(m_div, 200, "R1 m");
    check(n_div, 0, "R1 n");
    check(test_sel, 0, "R1 t");
    check(sout, 0, "R1 sout");
    check(m_range_err, 0, "R1 err");
    rst_n = 1'b1;
    step();

    for (int m = 0; m < 512; m++) par_load(m, m % 4);

    for (int t = 0; t < 8; t++)
      for (int n = 0; n < 4; n++) begin
        mlist = '{0, 124, 125, 200, 350, 351, 511, t*37 + n*11 + 100};
        foreach (mlist[k]) ser_load(mlist[k], n, t);
      end

    // R5: track an extra shift while sload stays high
    f = {3'd3, 2'd1, 9'd300};
    shift_frame(f);
    sload = 1'b1; step();
    check(m_div, 300, "R5 before extra");
    sdata = 1'b1; sclk = 1'b1; step(); sclk = 1'b0; step();
    f = {f[12:0], 1'b1};
    check(m_div, f[8:0], "R5 extra shift m");
    check(n_div, f[10:9], "R5 extra shift n");
    sload = 1'b0; step();
    check(m_div, f[8:0], "R6 after extra");
    check(test_sel, f[13:11], "R7 after extra");

    // R9: serial traffic ignored while parallel strobe low
    ser_load(300, 2, 6);
    pload_n = 1'b0; m_pin = 9'd150; n_pin = 2'd1; step();
    shift_frame({3'd1, 2'd3, 9'd50});
    sload = 1'b1; step(); step(); sload = 1'b0; step();
    check(m_div, 150, "R9 pins win");
    check(test_sel, 0, "R7 par mode");
    pload_n = 1'b1; step();
    check(m_div, 150, "R9 no latch");
    check(test_sel, 0, "R7 par mode kept");
    check(sout, 1, "R9 sout old frame");
    sload = 1'b1; step();
    check(m_div, 300, "R9 shreg kept m");
    check(n_div, 2, "R9 shreg kept n");
    sload = 1'b0; step();
    check(test_sel, 6, "R7 serial restores");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule